// File: doc/BRIEF.md
# Bit-Stream Pattern Checker with Window-Based Lock

This block checks a serial bit stream, taken from a line payload upstream, against a known test sequence. Each cycle with the valid strobe high delivers one bit. The bit may be complemented first and is then compared with the next bit the checker expects. The expected sequence is either a repeating word of programmable length or a pseudo-random sequence. The pseudo-random sequence uses the same length and feedback tap settings that a matching generator uses.

After reset, or after a restart, the checker searches for alignment and declares lock after 48 agreeing bits in a row. While locked, it pulses an error flag for every bit that disagrees. It counts those errors in consecutive, non-overlapping blocks of 48 bits, and drops lock once a block collects more than ten. A new search then starts by itself, or waits for a rising edge on the manual restart input, depending on a configuration bit. Three event kinds raise a one-cycle interrupt, each behind its own enable: a bit error, a change of lock state, and an externally supplied counter-update pulse.

Top module: `pattern_sync_detector`

## Requirements
- R1: After reset, `in_sync`, `bit_err` and `irq` are 0 and the checker is searching.
- R2: With `rx_invert` = 1, every incoming bit is complemented before the comparison. A complemented stream then locks, and it does not lock with `rx_invert` = 0.
- R3: With `prbs_mode` = 0, the expected sequence is `rep_pattern[0]`, `rep_pattern[1]` … `rep_pattern[pat_len]`, repeating, so its length is `pat_len`+1. The search slips its phase by one bit on each mismatch. `in_sync` rises one cycle after the 48th consecutive agreeing bit, and never before 48 valid bits have been received.
- R4: With `prbs_mode` = 1, the expected bit n is bit(n−`pat_len`−1) XOR bit(n−1−`tap`). While searching, the checker first takes `pat_len`+1 incoming bits into its history, and then needs 48 consecutive correct predictions to lock.
- R5: While locked, each valid bit that differs from the expected bit gives a one-cycle `bit_err` pulse in the following cycle. A matching bit gives none.
- R6: While locked in pseudo-random mode, the reference runs on its own predictions, so one corrupted bit gives exactly one `bit_err` pulse.
- R7: Errors are tallied over blocks of 48 valid bits, counted from the moment of lock. The 11th error within one block clears `in_sync` in the following cycle. The tally restarts at each block boundary, so up to 10 errors per block keep lock.
- R8: With `auto_resync` = 1, a new search starts at once after a loss of lock, and a clean stream locks again.
- R9: With `auto_resync` = 0, the checker stays out of lock after a loss, whatever data arrives, until a rising edge on `manual_sync`.
- R10: A rising edge of `manual_sync` clears lock in the next cycle and restarts the search. The bit presented in that cycle is discarded. Holding `manual_sync` high has no further effect.
- R11: `irq` is high for one cycle, aligned with `bit_err`, when any enabled event occurred in the previous cycle. The events are: a bit error (`err_ie`), a lock-state change (`sync_ie`), or `cnt_update` high (`upd_ie`). A disabled event leaves `irq` at 0.
- R12: A cycle with `bit_valid` = 0 (and no restart edge) leaves lock state, phase and tallies unchanged and gives no `bit_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Received payload bit |
| rx_invert | input | 1 | Complement incoming bits before comparing |
| prbs_mode | input | 1 | 0 = repeating word, 1 = pseudo-random |
| pat_len | input | 5 | Sequence length minus one (1..31) |
| tap | input | 5 | Feedback tap for pseudo-random mode, below `pat_len` |
| rep_pattern | input | 32 | Repeating word, bit 0 sent first |
| auto_resync | input | 1 | Restart the search automatically after loss of lock |
| manual_sync | input | 1 | Rising edge restarts the search |
| cnt_update | input | 1 | Counter-update event from outside |
| err_ie | input | 1 | Interrupt enable, bit errors |
| sync_ie | input | 1 | Interrupt enable, lock changes |
| upd_ie | input | 1 | Interrupt enable, counter updates |
| in_sync | output | 1 | Locked to the expected sequence |
| bit_err | output | 1 | One-cycle pulse per errored bit |
| irq | output | 1 | Combined interrupt request pulse |

## Verification
The assertions assume that the configuration inputs (`prbs_mode`, `pat_len`, `tap`, `rep_pattern`, `rx_invert`) are changed only while a restart is pending. They also assume that `tap` is below `pat_len` and that `manual_sync` is low when reset is released. The bench respects this: it alters settings only between bursts and follows each change with a clean low-high-low pulse on `manual_sync`. It also keeps every seed and word non-zero and drives inputs just after the falling edge.

// File: rtl/pattern_sync_detector.sv
module pattern_sync_detector #(
  parameter int MAXW = 32,
  parameter int WIN = 48,
  parameter int ERR_LIMIT = 10,
  localparam int LW = $clog2(MAXW),
  localparam int CW = $clog2(WIN),
  localparam int EW = $clog2(ERR_LIMIT + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_valid,
  input  logic            bit_in,
  input  logic            rx_invert,
  input  logic            prbs_mode,
  input  logic [LW-1:0]   pat_len,
  input  logic [LW-1:0]   tap,
  input  logic [MAXW-1:0] rep_pattern,
  input  logic            auto_resync,
  input  logic            manual_sync,
  input  logic            cnt_update,
  input  logic            err_ie,
  input  logic            sync_ie,
  input  logic            upd_ie,
  output logic            in_sync,
  output logic            bit_err,
  output logic            irq
);

  typedef enum logic [1:0] {SEARCH, LOCKED, HOLD} st_t;

  st_t             state;
  logic [LW-1:0]   ptr;
  logic [MAXW-1:0] hist;
  logic [LW:0]     fill;
  logic [CW-1:0]   match_cnt;
  logic [CW-1:0]   win_cnt;
  logic [EW-1:0]   err_cnt;
  logic            man_q;

  wire [LW:0]   len       = {1'b0, pat_len} + 1'b1;
  wire          d         = bit_in ^ rx_invert;
  wire          exp_bit   = prbs_mode ? (hist[pat_len] ^ hist[tap]) : rep_pattern[ptr];
  wire          mism      = d ^ exp_bit;
  wire          fill_ok   = !prbs_mode || (fill == len);
  wire          man_rise  = manual_sync & ~man_q;
  wire          step      = bit_valid & ~man_rise;
  wire          locked    = (state == LOCKED);
  wire          err_now   = step & locked & mism;
  wire          lose      = err_now && (err_cnt == EW'(ERR_LIMIT));
  wire          last_bit  = (win_cnt == CW'(WIN - 1));
  wire          acquire   = step && (state == SEARCH) && fill_ok && !mism &&
                            (match_cnt == CW'(WIN - 1));
  wire          sync_chg  = (locked && (man_rise || lose)) || acquire;
  wire [LW-1:0] ptr_next  = (ptr == pat_len) ? '0 : ptr + 1'b1;

  assign in_sync = locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEARCH;
      ptr       <= '0;
      hist      <= '0;
      fill      <= '0;
      match_cnt <= '0;
      win_cnt   <= '0;
      err_cnt   <= '0;
      man_q     <= 1'b0;
      bit_err   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      man_q   <= manual_sync;
      bit_err <= err_now;
      irq     <= (err_ie & err_now) | (sync_ie & sync_chg) | (upd_ie & cnt_update);
      if (man_rise) begin
        state     <= SEARCH;
        match_cnt <= '0;
        fill      <= '0;
      end else if (bit_valid) begin
        ptr <= ptr_next;
        case (state)
          SEARCH: begin
            hist <= {hist[MAXW-2:0], d};
            if (fill != len) fill <= fill + 1'b1;
            if (fill_ok) begin
              if (mism) begin
                match_cnt <= '0;
                if (!prbs_mode) ptr <= ptr;
              end else if (acquire) begin
                state     <= LOCKED;
                match_cnt <= '0;
                win_cnt   <= '0;
                err_cnt   <= '0;
              end else begin
                match_cnt <= match_cnt + 1'b1;
              end
            end
          end
          LOCKED: begin
            hist    <= {hist[MAXW-2:0], exp_bit};
            win_cnt <= last_bit ? '0 : win_cnt + 1'b1;
            err_cnt <= last_bit ? '0 : err_cnt + EW'(mism);
            if (lose) begin
              state     <= auto_resync ? SEARCH : HOLD;
              match_cnt <= '0;
              fill      <= '0;
            end
          end
          HOLD: hist <= {hist[MAXW-2:0], d};
          default: state <= SEARCH;
        endcase
      end
    end
  end

  // R5
  err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(in_sync));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !man_rise) |=> ($stable(in_sync) && !bit_err));

  // R7
  tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> (err_cnt <= EW'(ERR_LIMIT) && win_cnt < CW'(WIN)));

  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(match_cnt) == CW'(WIN - 1));

  // R9
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HOLD && !man_rise) |=> state == HOLD);

  // R10
  manual_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rise |=> !in_sync);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((bit_err && $past(err_ie)) ||
             ($past(sync_ie) && (in_sync != $past(in_sync))) ||
             $past(upd_ie && cnt_update)));

endmodule

// File: tb/pattern_sync_detector_tb.sv
`timescale 1ns/1ps
module pattern_sync_detector_tb;

  logic clk = 0, rst_n = 0;
  logic bit_valid = 0, bit_in = 0, rx_invert = 0, prbs_mode = 0;
  logic [4:0] pat_len = 5'd7, tap = 5'd0;
  logic [31:0] rep_pattern = 32'h0000_00B4;
  logic auto_resync = 1, manual_sync = 0, cnt_update = 0;
  logic err_ie = 0, sync_ie = 0, upd_ie = 0;
  logic in_sync, bit_err, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pattern_sync_detector u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .rx_invert(rx_invert), .prbs_mode(prbs_mode), .pat_len(pat_len), .tap(tap),
    .rep_pattern(rep_pattern), .auto_resync(auto_resync), .manual_sync(manual_sync),
    .cnt_update(cnt_update), .err_ie(err_ie), .sync_ie(sync_ie), .upd_ie(upd_ie),
    .in_sync(in_sync), .bit_err(bit_err), .irq(irq));

  // reference model state
  int ms = 0;            // 0 search, 1 locked, 2 waiting for manual edge
  int mptr = 0, mfill = 0, mmatch = 0, mwin = 0, merr = 0;
  bit mhist[$];
  bit mman = 0;
  bit e_sync = 0, e_err = 0, e_irq = 0;

  // stimulus generator
  int gptr = 0;
  bit gq[$];

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit d, pred, rise, chg, err, mm, slip, ok;
    int L;
    d = bit_in ^ rx_invert;
    L = int'(pat_len) + 1;
    pred = prbs_mode ? (mhist[pat_len] ^ mhist[tap]) : rep_pattern[mptr];
    rise = manual_sync && !mman;
    mman = manual_sync;
    chg = 0; err = 0; slip = 0;
    if (rise) begin
      if (ms == 1) chg = 1;
      ms = 0; mmatch = 0; mfill = 0;
    end else if (bit_valid) begin
      mm = (d != pred);
      if (ms == 0) begin
        ok = !prbs_mode || (mfill == L);
        if (mfill < L) mfill++;
        mhist.push_front(d); void'(mhist.pop_back());
        if (ok) begin
          if (mm) begin mmatch = 0; slip = !prbs_mode; end
          else if (mmatch == 47) begin
            ms = 1; chg = 1; mwin = 0; merr = 0; mmatch = 0;
          end else mmatch++;
        end
      end else if (ms == 1) begin
        mhist.push_front(pred); void'(mhist.pop_back());
        if (mm) begin err = 1; merr++; end
        if (merr > 10) begin
          ms = auto_resync ? 0 : 2; chg = 1; mmatch = 0; mfill = 0;
        end else begin
          if (mwin == 47) begin mwin = 0; merr = 0; end
          else mwin++;
        end
      end else begin
        mhist.push_front(d); void'(mhist.pop_back());
      end
      if (!slip) mptr = (mptr == int'(pat_len)) ? 0 : mptr + 1;
    end
    e_err = err;
    e_sync = (ms == 1);
    e_irq = (err_ie & err) | (sync_ie & chg) | (upd_ie & cnt_update);
  endtask

  task automatic tick(input logic v, input logic b);
    bit_valid = v; bit_in = b;
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R3/R4/R7", in_sync, e_sync, "in_sync vs model");
    chk("R5", bit_err, e_err, "bit_err vs model");
    chk("R11", irq, e_irq, "irq vs model");
  endtask

  function automatic bit gen();
    bit b;
    if (!prbs_mode) begin
      b = rep_pattern[gptr];
      gptr = (gptr == int'(pat_len)) ? 0 : gptr + 1;
    end else begin
      b = gq[pat_len] ^ gq[tap];
      gq.push_front(b); void'(gq.pop_back());
    end
    return b;
  endfunction

  task automatic send(input int n, input bit flip, input bit inv);
    for (int i = 0; i < n; i++) tick(1, gen() ^ flip ^ inv);
  endtask

  task automatic restart();
    manual_sync = 1; tick(0, 0);
    manual_sync = 0; tick(0, 0);
  endtask

  task automatic prbs_seed();
    gq.delete();
    for (int i = 0; i < 32; i++) gq.push_back(i % 3 == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    for (int i = 0; i < 32; i++) mhist.push_back(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", in_sync, 0, "in_sync after reset");
    chk("R1", bit_err, 0, "bit_err after reset");
    chk("R1", irq, 0, "irq after reset");

    // R3 repeating word, started off phase
    gptr = 3;
    send(47, 0, 0);
    chk("R3", in_sync, 0, "no lock before 48 bits");
    send(200, 0, 0);
    chk("R3", in_sync, 1, "repeating word locks");

    // R5 single error
    send(1, 1, 0);
    chk("R5", bit_err, 1, "errored bit flagged");
    send(1, 0, 0);
    chk("R5", bit_err, 0, "clean bit not flagged");

    // R7 ten errors per block keep lock
    for (int i = 0; i < 150; i++) send(1, (i % 5) == 0, 0);
    chk("R7", in_sync, 1, "spaced errors keep lock");

    // R7 R8 burst of 11 with automatic restart, irq on sync change
    send(60, 0, 0);
    sync_ie = 1;
    send(10, 1, 0);
    chk("R7", in_sync, 1, "ten errors tolerated");
    send(1, 1, 0);
    chk("R7", in_sync, 0, "11th error drops lock");
    chk("R11", irq, 1, "irq on lock change");
    sync_ie = 0;
    send(200, 0, 0);
    chk("R8", in_sync, 1, "automatic relock");

    // R9 hold until manual edge
    auto_resync = 0;
    send(11, 1, 0);
    send(200, 0, 0);
    chk("R9", in_sync, 0, "stays out of lock");
    restart();
    send(200, 0, 0);
    chk("R9", in_sync, 1, "manual edge relocks");

    // R10 manual edge while locked, held high
    manual_sync = 1; tick(1, gen());
    chk("R10", in_sync, 0, "manual edge drops lock");
    send(200, 0, 0);
    chk("R10", in_sync, 1, "held high restarts once");
    manual_sync = 0; tick(0, 0);
    auto_resync = 1;

    // R12 idle cycles with corrupted data
    cnt = 0;
    for (int i = 0; i < 20; i++) begin tick(0, ~bit_in); cnt += bit_err; end
    chk("R12", cnt == 0, 1, "no error while invalid");
    chk("R12", in_sync, 1, "lock held while invalid");
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 2) == 0) tick(0, $urandom_range(0, 1));
      else send(1, 0, 0);
    end
    chk("R12", in_sync, 1, "lock through gaps");

    // R11 enables
    err_ie = 0; send(1, 1, 0);
    chk("R11", irq, 0, "disabled error no irq");
    err_ie = 1; send(1, 1, 0);
    chk("R11", irq, 1, "enabled error irq");
    err_ie = 0; upd_ie = 1; cnt_update = 1; send(1, 0, 0);
    cnt_update = 0;
    chk("R11", irq, 1, "update irq");
    upd_ie = 0;

    // R4 pseudo-random, length 7, tap 5
    prbs_mode = 1; pat_len = 5'd6; tap = 5'd5;
    prbs_seed();
    restart();
    send(200, 0, 0);
    chk("R4", in_sync, 1, "pseudo-random locks");
    // R6 one error, one pulse
    send(1, 1, 0);
    cnt = bit_err;
    for (int i = 0; i < 20; i++) begin send(1, 0, 0); cnt += bit_err; end
    chk("R6", cnt == 1, 1, "single pulse per error");

    // R2 inversion
    restart();
    send(200, 0, 1);
    chk("R2", in_sync, 0, "complemented stream no lock");
    rx_invert = 1;
    restart();
    send(200, 0, 1);
    chk("R2", in_sync, 1, "complemented stream locks with invert");

    // R4 other length and tap
    rx_invert = 0; pat_len = 5'd14; tap = 5'd13;
    prbs_seed();
    restart();
    send(300, 0, 0);
    chk("R4", in_sync, 1, "length 15 locks");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule